// File: doc/BRIEF.md
# Indexed Colour Palette with Sequenced Component Writes

This block holds a 256-entry colour lookup table. Each entry stores an 8-bit red, green and blue value. A host loads the table through a small 32-bit register window that spans 16 bytes. One register selects the entry. A second register takes the three colour components in turn, and a phase sequencer steers each write to red, then green, then blue. After blue, the selected entry advances by one, so a whole palette can be streamed with a single index write followed by a run of data writes. Only the top byte of each 32-bit write carries a value.

A separate lookup port serves a display pipeline. It is read-only: it takes an 8-bit pixel code and returns the 24-bit colour held for that code, with no added latency. After reset the table is all black, except the last entry, which is white. Reads through the register window always return zero.

Top module: `pal_lut`

## Requirements
- R1: After reset every entry reads back as 24'h000000, except entry 255, which reads 24'hFFFFFF. The selected index and the phase are cleared, so the first data write lands in the red component of entry 0.
- R2: A full write to byte offset 0 loads the selected index from write-data bits 31:24 and resets the phase to red. The lower 24 bits are ignored.
- R3: Full writes to byte offset 4 store write-data bits 31:24 into the red, green and blue components of the selected entry, in that order, with one component per write.
- R4: The write that stores blue advances the selected index by one modulo 256, so 255 is followed by 0, and it returns the phase to red.
- R5: Writes to any offset other than 0 and 4 (for example 1, 8 or 12) change neither the table, the index nor the phase.
- R6: A write whose byte strobe is anything other than 4'b1111 is ignored entirely.
- R7: The read data of the register window is zero for every offset.
- R8: The lookup output is {red, green, blue}, with red in bits 23:16 and blue in bits 7:0. It is combinational in the lookup index, and a component write becomes visible on the lookup output in the cycle that follows the write edge.
- R9: An index write in the middle of a component sequence abandons that sequence. Components already stored stay stored, and the next data write targets red of the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register window write strobe |
| bus_rd | input | 1 | Register window read strobe (reads return zero) |
| bus_addr | input | 4 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data; only bits 31:24 are used |
| bus_wstrb | input | 4 | Byte-lane strobes; only 4'b1111 is accepted |
| bus_rdata | output | 32 | Read data, always zero |
| lk_idx | input | 8 | Pixel code for the lookup port |
| lk_rgb | output | 24 | Colour for lk_idx as {red, green, blue} |

## Verification
A register-window write is captured at the rising edge on which bus_wr is high. Its effect on the index, the phase and the table is therefore due one edge later, and the lookup output shows it from the following falling edge onward. Lookup and read data are combinational, so they are due in the same cycle that their inputs change. The bench drives every input at a falling edge and samples outputs a little after the falling edge. It compares the output with a behavioural palette model that is updated at each rising edge. Directed checks sample at that same point, and one check also samples before the write edge to confirm that the old colour is still shown.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned NUM_COMP = 3;
  localparam int unsigned OFF_INDEX = 0;
  localparam int unsigned OFF_DATA  = 4;
  localparam int unsigned STRB_W    = 4;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2,
    PH_BAD = 2'd3
  } phase_e;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idx_ld,
  input  logic                dat_wr,
  input  logic [IDX_W-1:0]    ld_val,
  output logic [IDX_W-1:0]    idx,
  output phase_e              phase,
  output logic [NUM_COMP-1:0] comp_we
);
  logic [IDX_W-1:0] idx_n;
  phase_e           phase_n;
  logic             upd_en;

  // next-state: index and component phase
  always_comb begin
    idx_n   = idx;
    phase_n = phase;
    comp_we = '0;
    if (idx_ld) begin
      idx_n   = ld_val;
      phase_n = PH_RED;
    end else if (dat_wr) begin
      unique case (phase)
        PH_RED: begin
          comp_we[0] = 1'b1;
          phase_n    = PH_GRN;
        end
        PH_GRN: begin
          comp_we[1] = 1'b1;
          phase_n    = PH_BLU;
        end
        PH_BLU: begin
          comp_we[2] = 1'b1;
          phase_n    = PH_RED;
          idx_n      = idx + 1'b1;
        end
        default: phase_n = PH_RED; // unreachable code: recover, store nothing
      endcase
    end
  end

  assign upd_en = idx_ld | dat_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (upd_en) begin
      idx   <= idx_n;
      phase <= phase_n;
    end
  end

  // R3: at most one component written per data write; phase never illegal
  assert_one_comp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comp_we));
  assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_BAD);
  assert_red_to_grn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idx_ld && phase == PH_RED) |=> phase == PH_GRN);
  // R2 / R9: index load restarts at red
  assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ld |=> (idx == $past(ld_val) && phase == PH_RED));
  // R4: blue advances the index modulo 2**IDX_W
  assert_idx_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !idx_ld && phase == PH_BLU) |=> (idx == IDX_W'($past(idx) + 1'b1) && phase == PH_RED));
endmodule

// File: rtl/pal_bank.sv
module pal_bank #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // reset fill: black everywhere, full scale in the last entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= (i == DEPTH - 1) ? {DW{1'b1}} : {DW{1'b0}};
      end
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R8: a stored component is readable at its address one edge later
  assert_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && raddr == waddr) |=> ($stable(raddr) -> rdata == $past(wdata)));
endmodule

// File: rtl/pal_lut.sv
module pal_lut
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned COMP_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic [DATA_W/8-1:0]        bus_wstrb,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [IDX_W-1:0]           lk_idx,
  output logic [NUM_COMP*COMP_W-1:0] lk_rgb
);
  localparam int unsigned RGB_W = NUM_COMP * COMP_W;

  logic                full_wr;
  logic                idx_ld;
  logic                dat_wr;
  logic [IDX_W-1:0]    idx;
  phase_e              phase;
  logic [NUM_COMP-1:0] comp_we;
  logic [COMP_W-1:0]   comp_rd [NUM_COMP];
  logic                unused_bits;

  // decode: only complete word writes at the two live offsets count
  assign full_wr = bus_wr && (&bus_wstrb);
  assign idx_ld  = full_wr && (bus_addr == ADDR_W'(OFF_INDEX));
  assign dat_wr  = full_wr && (bus_addr == ADDR_W'(OFF_DATA));

  assign bus_rdata   = '0;
  assign unused_bits = ^{bus_rd, bus_wdata[DATA_W-COMP_W-1:0]};

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_ld  (idx_ld),
    .dat_wr  (dat_wr),
    .ld_val  (bus_wdata[DATA_W-1 -: IDX_W]),
    .idx     (idx),
    .phase   (phase),
    .comp_we (comp_we)
  );

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    pal_bank #(.AW(IDX_W), .DW(COMP_W)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (comp_we[c]),
      .waddr (idx),
      .wdata (bus_wdata[DATA_W-1 -: COMP_W]),
      .raddr (lk_idx),
      .rdata (comp_rd[c])
    );
    // red (component 0) in the top byte
    assign lk_rgb[RGB_W - c*COMP_W - 1 -: COMP_W] = comp_rd[c];
  end

  // R5: stray offsets leave the sequencer untouched
  assert_ignore_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != ADDR_W'(OFF_INDEX) && bus_addr != ADDR_W'(OFF_DATA))
      |=> ($stable(idx) && $stable(phase)));
  // R6: partial strobes leave the sequencer untouched
  assert_ignore_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !(&bus_wstrb)) |=> ($stable(idx) && $stable(phase)));
  // R3: no component write without a data-offset write
  assert_we_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|comp_we) |-> (bus_wr && bus_addr == ADDR_W'(OFF_DATA)));
endmodule

// File: tb/pal_lut_bench.sv
module pal_lut_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_wstrb;
  logic [31:0] bus_rdata;
  logic [7:0]  lk_idx;
  logic [23:0] lk_rgb;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // behavioural model
  byte unsigned mr [256];
  byte unsigned mg [256];
  byte unsigned mb [256];
  int midx;
  int mph;

  always #5 clk = ~clk;

  pal_lut u_pal_lut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_rdata(bus_rdata), .lk_idx(lk_idx), .lk_rgb(lk_rgb)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // model update at each rising edge
  always @(posedge clk) begin
    if (rst_n && bus_wr && bus_wstrb == 4'hF) begin
      if (bus_addr == 4'd0) begin
        midx = int'(bus_wdata[31:24]);
        mph  = 0;
      end else if (bus_addr == 4'd4) begin
        case (mph)
          0: begin mr[midx] = bus_wdata[31:24]; mph = 1; end
          1: begin mg[midx] = bus_wdata[31:24]; mph = 2; end
          default: begin
            mb[midx] = bus_wdata[31:24];
            mph = 0;
            midx = (midx + 1) % 256;
          end
        endcase
      end
    end
  end

  // every-cycle comparison, 2 ns after the falling edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n === 1'b1) begin
      check("R8 lookup", {8'h0, lk_rgb}, {8'h0, mr[lk_idx], mg[lk_idx], mb[lk_idx]});
      check("R7 rdata", bus_rdata, 32'h0);
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] s = 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 32'h0; bus_wstrb = 4'h0;
  endtask

  task automatic look(string tag, logic [7:0] i, logic [23:0] exp);
    lk_idx = i;
    #1;
    check(tag, {8'h0, lk_rgb}, {8'h0, exp});
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mr[i] = (i == 255) ? 8'hFF : 8'h0;
      mg[i] = (i == 255) ? 8'hFF : 8'h0;
      mb[i] = (i == 255) ? 8'hFF : 8'h0;
    end
    midx = 0; mph = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    bus_wdata = '0; bus_wstrb = '0; lk_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset contents
    look("R1 entry0", 8'd0, 24'h000000);
    look("R1 entry100", 8'd100, 24'h000000);
    look("R1 entry254", 8'd254, 24'h000000);
    look("R1 entry255", 8'd255, 24'hFFFFFF);
    // R1/R3 first data writes land on entry 0 red, green, blue
    wr(4'd4, 32'hAA00_0000);
    wr(4'd4, 32'hBB12_3456);
    wr(4'd4, 32'hCC00_0000);
    look("R3 entry0 rgb", 8'd0, 24'hAABBCC);
    // R2 index load ignoring low bits; R9 mid-sequence restart
    wr(4'd0, 32'h10FF_FFFF);
    wr(4'd4, 32'h1100_0000);
    wr(4'd4, 32'h2200_0000);
    wr(4'd0, 32'h2000_0000);
    wr(4'd4, 32'h3300_0000);
    wr(4'd4, 32'h4400_0000);
    wr(4'd4, 32'h5500_0000);
    look("R9 entry10 partial", 8'h10, 24'h112200);
    look("R2 entry20", 8'h20, 24'h334455);
    // R4 wrap 255 -> 0
    wr(4'd0, 32'hFF00_0000);
    wr(4'd4, 32'h0100_0000);
    wr(4'd4, 32'h0200_0000);
    wr(4'd4, 32'h0300_0000);
    wr(4'd4, 32'h7700_0000);
    look("R4 entry255", 8'hFF, 24'h010203);
    look("R4 wrapped to entry0", 8'h00, 24'h77BBCC);
    // R5 stray offsets
    wr(4'd8, 32'hEE00_0000);
    wr(4'd1, 32'hEE00_0000);
    wr(4'd12, 32'hEE00_0000);
    look("R5 entry0 untouched", 8'h00, 24'h77BBCC);
    wr(4'd4, 32'h6600_0000);
    look("R5 phase kept at green", 8'h00, 24'h7766CC);
    // R6 partial strobes
    wr(4'd4, 32'h9900_0000, 4'h7);
    wr(4'd0, 32'h9900_0000, 4'h8);
    look("R6 entry0 untouched", 8'h00, 24'h7766CC);
    wr(4'd4, 32'h5500_0000);
    look("R6 index/phase kept", 8'h00, 24'h776655);
    // R7 reads
    for (int a = 0; a < 16; a += 4) begin
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 4'(a);
      #1;
      check("R7 read zero", bus_rdata, 32'h0);
    end
    @(negedge clk);
    bus_rd = 1'b0;
    // R8 timing: old colour before the edge, new one after it (entry 1 red)
    lk_idx = 8'd1;
    bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 32'hDE00_0000; bus_wstrb = 4'hF;
    #1;
    check("R8 before edge", {8'h0, lk_rgb}, 32'h0);
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    check("R8 after edge", {8'h0, lk_rgb}, 32'h00DE0000);
    // mixed traffic, compared every cycle against the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      bus_wr    = ($urandom_range(0, 3) != 0);
      bus_addr  = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 15)) :
                  (($urandom_range(0, 9) == 0) ? 4'd0 : 4'd4);
      bus_wdata = $urandom;
      bus_wstrb = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'hF;
      lk_idx    = ($urandom_range(0, 1) == 0) ? 8'(midx) : 8'($urandom_range(0, 255));
    end
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule